// File: doc/BRIEF.md
# Soft-Mute Output Attenuator

This block scales a pair of 24-bit audio samples, left and right, by a gain taken from a 7-bit attenuation code. The gain never jumps. A single level register moves one code at a time, on frame strobes, towards a target. A Bresenham-style frame counter spaces the steps so that a full sweep of 127 codes takes a fixed number of frames. A soft-mute request sends the level down to silence over 1024 frames. If the request is dropped partway, the ramp turns round and climbs back to the programmed code. A code written during normal running is approached at the same rate.

The power-enable input, active low for power-down, holds the block silent while it is low. When it rises, the level fades in from silence to full scale over 8031 frames, whatever code is applied. After the fade ends, the programmed code takes over. Samples enter on the frame strobe. The scaled result appears on the outputs one clock later and holds until the next strobe.

Top module: `soft_mute_atten`

## Requirements
- R1: While `rst_n` or `pwr_n` is low, both outputs are zero and the internal level is forced to code 00h, so the next fade starts from silence.
- R2: Gain uses 12 fractional bits. Code bits [6:4] are a segment s and bits [3:0] are a step t. For s = 0 the gain is t. Otherwise the gain is (17 + t) shifted left by s. So 7Fh gives exactly 4096 (unity) and 00h gives silence.
- R3: On a clock with `frame_stb` high and `pwr_n` high, each output is loaded with (in × gain + 2048) arithmetically shifted right by 12, using the level held before that edge. Between strobes the outputs hold their value, whatever the inputs do.
- R4: After `pwr_n` rises, n strobes later the level is floor(127·n/8031), reaching 7Fh at strobe 8031 regardless of `atten_code`. The fade mode ends on the first strobe that finds the level at 7Fh.
- R5: With `mute_req` high, the level falls towards 00h. Steps follow a frame counter that gains 127 per strobe and issues a step, losing 1024, whenever it reaches 1024. From a settled 7Fh, the level after n strobes is 127 − floor(127·n/1024), and silence follows exactly 1024 strobes.
- R6: Releasing `mute_req` before the ramp ends reverses it: the level climbs back towards `atten_code` at the 1024-frame rate, without resetting the frame counter.
- R7: Outside fade and mute, a change of `atten_code` is approached one code per step at the 1024-frame rate. The frame counter clears on any strobe that finds the level equal to its target.
- R8: A mute request during the fade ends the fade on that strobe, with no level step and the counter cleared. From the next strobe the mute ramp runs at the 1024-frame rate.
- R9: The level moves by at most one code per clock, and only on a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_n | input | 1 | Power enable, low forces silence; rising edge starts the fade-in |
| frame_stb | input | 1 | One-clock strobe per sample frame |
| mute_req | input | 1 | Soft-mute request |
| atten_code | input | 7 | Programmed attenuation code, 7Fh = 0 dB |
| in_l | input | 24 | Left input sample, two's complement |
| in_r | input | 24 | Right input sample, two's complement |
| out_l | output | 24 | Attenuated left sample |
| out_r | output | 24 | Attenuated right sample |

## Verification
The gain path is exercised with random full-range samples on both channels at every frame. This separates sign handling, rounding and segment decoding in the gain. Fixed-code checks at 40h and 7Fh tie those results to exact gain values.

The ramps are exercised in several patterns, each of which a rate or direction fault would change:
- a complete fade with a non-default code applied;
- a full mute from unity;
- a mute released midway;
- a mute that interrupts a fade;
- random code writes and mute toggles with power-down pulses.

Each ramp frame is compared with closed-form level formulas and with a frame-by-frame level model. Input changes between strobes show whether the outputs hold.

// File: rtl/soft_mute_atten.sv
module soft_mute_atten #(
  parameter int DW          = 24,
  parameter int SEG_W       = 3,
  parameter int STEP_W      = 4,
  parameter int MUTE_FRAMES = 1024,
  parameter int FADE_FRAMES = 8031
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_n,
  input  logic                 frame_stb,
  input  logic                 mute_req,
  input  logic [SEG_W+STEP_W-1:0] atten_code,
  input  logic [DW-1:0]        in_l,
  input  logic [DW-1:0]        in_r,
  output logic [DW-1:0]        out_l,
  output logic [DW-1:0]        out_r
);
  localparam int CW   = SEG_W + STEP_W;
  localparam int TOP  = (1 << CW) - 1;
  localparam int FRAC = STEP_W + (1 << SEG_W);
  localparam int GW   = FRAC + 1;
  localparam int PW   = DW + GW + 1;
  localparam int FMAX = (FADE_FRAMES > MUTE_FRAMES) ? FADE_FRAMES : MUTE_FRAMES;
  localparam int AW   = $clog2(FMAX + TOP + 1);
  localparam logic [PW-1:0] HALF = PW'(1) << (FRAC - 1);

  logic [CW-1:0]   lvl, tgt;
  logic            fading;
  logic [AW-1:0]   acc, span, acc_nx;
  logic [GW-1:0]   gain;
  logic signed [PW-1:0] prod_l, prod_r, rnd_l, rnd_r;

  wire [SEG_W-1:0]  seg = lvl[CW-1:STEP_W];
  wire [STEP_W-1:0] stp = lvl[STEP_W-1:0];

  assign tgt    = mute_req ? '0 : (fading ? CW'(TOP) : atten_code);
  assign span   = fading ? AW'(FADE_FRAMES) : AW'(MUTE_FRAMES);
  assign acc_nx = acc + AW'(TOP);

  always_comb begin
    if (seg == '0) gain = GW'(stp);
    else           gain = (GW'(1 << STEP_W) + GW'(1) + GW'(stp)) << seg;
  end

  assign prod_l = PW'($signed(in_l)) * $signed({{(PW-GW){1'b0}}, gain});
  assign prod_r = PW'($signed(in_r)) * $signed({{(PW-GW){1'b0}}, gain});
  assign rnd_l  = prod_l + $signed(HALF);
  assign rnd_r  = prod_r + $signed(HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= '0; fading <= 1'b1; acc <= '0; out_l <= '0; out_r <= '0;
    end else if (!pwr_n) begin
      lvl <= '0; fading <= 1'b1; acc <= '0; out_l <= '0; out_r <= '0;
    end else if (frame_stb) begin
      out_l <= rnd_l[FRAC+DW-1:FRAC];
      out_r <= rnd_r[FRAC+DW-1:FRAC];
      if (mute_req && fading) begin
        fading <= 1'b0;
        acc    <= '0;
      end else if (lvl == tgt) begin
        fading <= 1'b0;
        acc    <= '0;
      end else if (acc_nx >= span) begin
        acc <= acc_nx - span;
        lvl <= (lvl < tgt) ? lvl + CW'(1) : lvl - CW'(1);
      end else begin
        acc <= acc_nx;
      end
    end
  end

  p_silent_pd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> (out_l == '0 && out_r == '0 && lvl == '0));

  p_unity_gain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n && frame_stb && lvl == CW'(TOP)) |=> (out_l == $past(in_l) && out_r == $past(in_r)));

  p_fade_rises_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n && fading && !mute_req) |=> (lvl >= $past(lvl)));

  p_mute_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n && mute_req) |=> (lvl <= $past(lvl)));

  p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_n |=> (lvl == $past(lvl) || lvl == $past(lvl) + CW'(1) || lvl == $past(lvl) - CW'(1)));

  p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n && !frame_stb) |=> ($stable(lvl) && $stable(out_l) && $stable(out_r)));
endmodule

// File: tb/tb_soft_mute_atten.sv
module tb_soft_mute_atten;
  logic clk = 1'b0, rst_n = 1'b0, pwr_n = 1'b0, frame_stb = 1'b0, mute_req = 1'b0;
  logic [6:0] atten_code = 7'h7F;
  logic [23:0] in_l = '0, in_r = '0;
  logic [23:0] out_l, out_r;
  int n_chk = 0, n_fail = 0;
  int m_lvl = 0, m_acc = 0;
  bit m_fad = 1'b1, done = 1'b0;
  logic [23:0] last_in_l, last_out_l;

  always #5 clk = ~clk;

  soft_mute_atten dut (.clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .frame_stb(frame_stb),
    .mute_req(mute_req), .atten_code(atten_code), .in_l(in_l), .in_r(in_r),
    .out_l(out_l), .out_r(out_r));

  function automatic longint g(int c);
    int s = c >> 4, t = c & 15;
    return (s == 0) ? longint'(t) : longint'(17 + t) << s;
  endfunction

  function automatic logic [23:0] calc(logic [23:0] x, int c);
    longint p = longint'($signed(x)) * g(c);
    p = (p + 2048) >>> 12;
    return p[23:0];
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic m_powerdown();
    m_lvl = 0; m_acc = 0; m_fad = 1'b1;
  endtask

  task automatic m_step();
    int tg = mute_req ? 0 : (m_fad ? 127 : int'(atten_code));
    int sp = m_fad ? 8031 : 1024;
    if (mute_req && m_fad) begin m_fad = 1'b0; m_acc = 0; end
    else if (m_lvl == tg) begin m_fad = 1'b0; m_acc = 0; end
    else if (m_acc + 127 >= sp) begin
      m_acc = m_acc + 127 - sp;
      m_lvl = (m_lvl < tg) ? m_lvl + 1 : m_lvl - 1;
    end else m_acc = m_acc + 127;
  endtask

  task automatic frame(string req);
    logic [23:0] el, er;
    @(negedge clk);
    in_l = $urandom; in_r = $urandom; frame_stb = 1'b1;
    el = pwr_n ? calc(in_l, m_lvl) : 24'h0;
    er = pwr_n ? calc(in_r, m_lvl) : 24'h0;
    if (pwr_n) m_step();
    @(negedge clk);
    frame_stb = 1'b0;
    check(req, out_l, el);
    check(req, out_r, er);
    last_in_l = in_l; last_out_l = out_l;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B));
    repeat (3) @(negedge clk);
    check("R1 reset", out_l, 24'h0);
    rst_n = 1'b1;
    atten_code = 7'h40;
    for (int i = 0; i < 20; i++) frame("R1 powerdown");
    @(negedge clk); pwr_n = 1'b1; m_powerdown();
    for (int i = 0; i <= 8031; i++) begin
      frame("R4 fade model");
      check("R4 fade formula", last_out_l, calc(last_in_l, (127 * i) / 8031));
    end
    for (int i = 0; i < 1100; i++) frame("R7 code down");
    check("R2 code 40h", last_out_l, calc(last_in_l, 8'h40));
    @(negedge clk); in_l = 24'h800000; @(negedge clk); @(negedge clk);
    check("R3 hold", out_l, last_out_l);
    atten_code = 7'h7F;
    for (int i = 0; i < 1100; i++) frame("R7 code up");
    check("R2 unity", last_out_l, last_in_l);
    mute_req = 1'b1;
    for (int i = 0; i <= 1024; i++) begin
      frame("R5 mute model");
      check("R5 mute formula", last_out_l, calc(last_in_l, 127 - (127 * i) / 1024));
    end
    check("R5 silent", last_out_l, 24'h0);
    mute_req = 1'b0;
    for (int i = 0; i < 1100; i++) frame("R6 unmute");
    mute_req = 1'b1;
    for (int i = 0; i < 300; i++) frame("R5 partial");
    mute_req = 1'b0;
    for (int i = 0; i < 500; i++) frame("R6 reverse");
    check("R6 back to unity", last_out_l, last_in_l);
    @(negedge clk); pwr_n = 1'b0; m_powerdown();
    for (int i = 0; i < 5; i++) frame("R1 mid powerdown");
    @(negedge clk); pwr_n = 1'b1;
    for (int i = 0; i < 2000; i++) frame("R4 fade part");
    mute_req = 1'b1;
    for (int i = 0; i < 1100; i++) frame("R8 mute in fade");
    mute_req = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(199) == 0) atten_code = 7'($urandom);
      if ($urandom_range(299) == 0) mute_req = ~mute_req;
      if ($urandom_range(1499) == 0) begin
        @(negedge clk); pwr_n = 1'b0; m_powerdown();
        @(negedge clk); pwr_n = 1'b1;
      end
      frame("R9 random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule